// File: doc/BRIEF.md
# Register-mapped GPIO port with direction and pull control

This block is a general-purpose I/O port of up to 50 pins that a bus master programs through plain 16-bit registers. Each pin has an output value and an output enable that the block drives to the pad logic, and the pad's input level is synchronized and can be read back. The master performs any read-modify-write itself; the block only offers whole-register reads and writes.

Pins 0 to 31 are served by two direction registers and two data registers. The pins from 32 upward use a second pair of registers whose meaning depends on a build option. Without a dedicated enable register, pins 32 to 47 are output-only and pins 48 and 49 take their enables from two bits inside the top data register. With the enable register, one offset holds the enables and the other holds the data for pins 32 to 47. The first fifteen pins can also get a pull resistor, selected by one register that switches the pull on and another that picks its direction.

Three builds are intended: 50 pins with pull control and packed upper enables, 36 pins, and 48 pins (either enable scheme, at most 48 pins with the dedicated enable register).

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads 0, `pin_out`, `pull_en` and `pull_up` are all 0, and `pin_oe` is 0 except for output-only pins (pins 32 to 47 in the packed-enable build), whose enable is fixed at 1.
- R2: Offsets 0x000 and 0x002 hold the direction of pins 0-15 and 16-31 at bit (pin mod 16); 1 = output, 0 = input. `pin_oe` follows the register from the clock edge of the write.
- R3: Offsets 0x004 and 0x006 hold the output value of pins 0-15 and 16-31 at bit (pin mod 16) and drive `pin_out`; the pin outputs change only on a register write.
- R4: Reading a data register returns, per bit, the stored output value when that pin's enable is 1, and otherwise the pad input delayed by `SYNC_STAGES` clock cycles.
- R5: In the packed-enable build, offset 0x01C bits 0-15 are the data of pins 32-47 (always driven), offset 0x01E bits 0 and 1 are the data of pins 48 and 49, and bits 8 and 9 of 0x01E are the enables of pins 48 and 49.
- R6: In the dedicated-enable build, offset 0x01C bit (pin-32) is the enable of pins 32 and up, and offset 0x01E bit (pin-32) is their data.
- R7: Offset 0x1E0 bit p turns on the pull of pin p and offset 0x1E2 bit p selects its direction (1 = up, 0 = down), only for pins 0-14; other bits, and both registers in a build without pull control, read 0 and never drive `pull_en` or `pull_up`.
- R8: Clearing a pull enable leaves the pull direction register and `pull_up` unchanged.
- R9: Bits for pins at or above `NUM_PINS`, unused bits, odd offsets and unmapped offsets read 0 and ignore writes.
- R10: `rdata` is loaded on the clock edge where `rd_en` is 1 and holds otherwise; a read in the same cycle as a write to the same offset returns the value before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered |
| pin_in | input | NUM_PINS | Pad input levels |
| pin_out | output | NUM_PINS | Per-pin output value |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| pull_en | output | NUM_PINS | Per-pin pull enable |
| pull_up | output | NUM_PINS | Per-pin pull direction, 1 = up |

## Verification
The hardest case to reach is the mixed readback of the top data register in the packed-enable build, where two bits are pin data that switch between driven value and pad level, two bits are enables stored verbatim, and the rest must stay zero. The stimulus writes all ones there, then clears one packed enable and toggles that pin's pad input across the synchronizer delay, reading after each step. A second instance built with the dedicated enable register and no pull control checks the other mapping of the same two offsets.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int REG_W     = 16;
  localparam int NREG      = 8;
  localparam int PULL_PINS = 15;
  localparam int MAX_PINS  = 64;

  // register slots
  localparam int R_DIR_LO = 0;
  localparam int R_DIR_HI = 1;
  localparam int R_DAT_LO = 2;
  localparam int R_DAT_HI = 3;
  localparam int R_AUX0   = 4;
  localparam int R_AUX1   = 5;
  localparam int R_PEN    = 6;
  localparam int R_PUP    = 7;

  // special results of oe_loc
  localparam int LOC_NONE = -1;
  localparam int LOC_TIED = -2;

  function automatic int reg_offset(int idx);
    case (idx)
      R_DIR_LO: return 'h000;
      R_DIR_HI: return 'h002;
      R_DAT_LO: return 'h004;
      R_DAT_HI: return 'h006;
      R_AUX0:   return 'h01C;
      R_AUX1:   return 'h01E;
      R_PEN:    return 'h1E0;
      default:  return 'h1E2;
    endcase
  endfunction

  // flat bit location (slot*REG_W + bit) of a pin's output value
  function automatic int out_loc(int p, int npins, bit oe_reg);
    if (p >= npins) return LOC_NONE;
    if (p < 16) return R_DAT_LO * REG_W + p;
    if (p < 32) return R_DAT_HI * REG_W + p - 16;
    if (oe_reg) return (p < 48) ? R_AUX1 * REG_W + p - 32 : LOC_NONE;
    if (p < 48) return R_AUX0 * REG_W + p - 32;
    if (p < 50) return R_AUX1 * REG_W + p - 48;
    return LOC_NONE;
  endfunction

  // flat bit location of a pin's output enable
  function automatic int oe_loc(int p, int npins, bit oe_reg);
    if (p >= npins) return LOC_NONE;
    if (p < 16) return R_DIR_LO * REG_W + p;
    if (p < 32) return R_DIR_HI * REG_W + p - 16;
    if (oe_reg) return (p < 48) ? R_AUX0 * REG_W + p - 32 : LOC_NONE;
    if (p < 48) return LOC_TIED;
    if (p < 50) return R_AUX1 * REG_W + 8 + p - 48;
    return LOC_NONE;
  endfunction

  // implemented (writable) bits of one register slot
  function automatic logic [REG_W-1:0] wr_mask(int idx, int npins, bit oe_reg, bit pull);
    logic [REG_W-1:0] m;
    m = '0;
    for (int p = 0; p < npins && p < MAX_PINS; p++) begin
      int o;
      int e;
      o = out_loc(p, npins, oe_reg);
      e = oe_loc(p, npins, oe_reg);
      if (o >= 0 && o / REG_W == idx) m[o % REG_W] = 1'b1;
      if (e >= 0 && e / REG_W == idx) m[e % REG_W] = 1'b1;
      if (pull && p < PULL_PINS && (idx == R_PEN || idx == R_PUP)) m[p] = 1'b1;
    end
    return m;
  endfunction

  // pin whose data sits at a register bit, or LOC_NONE
  function automatic int data_pin(int idx, int b, int npins, bit oe_reg);
    for (int p = 0; p < npins && p < MAX_PINS; p++)
      if (out_loc(p, npins, oe_reg) == idx * REG_W + b) return p;
    return LOC_NONE;
  endfunction

endpackage

// File: rtl/gpio_reg16.sv
module gpio_reg16 #(
  parameter int W = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata & MASK;
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 50,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 50,
  parameter bit HAS_PULL    = 1'b1,
  parameter bit HAS_OE_REG  = 1'b0,
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wdata,
  output logic [REG_W-1:0]    rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pull_en,
  output logic [NUM_PINS-1:0] pull_up
);

  localparam int FLAT_W = NREG * REG_W;

  logic [NREG-1:0]     hit;
  logic [FLAT_W-1:0]   regs;
  logic [FLAT_W-1:0]   view;
  logic [NUM_PINS-1:0] pad_s;
  logic [NUM_PINS-1:0] rb;
  logic [REG_W-1:0]    sel;

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pad_s)
  );

  // register slots, their decode and their read view
  generate
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      localparam logic [ADDR_W-1:0] OFS = ADDR_W'(reg_offset(r));
      localparam logic [REG_W-1:0]  MSK = wr_mask(r, NUM_PINS, HAS_OE_REG, HAS_PULL);

      assign hit[r] = (addr == OFS);

      gpio_reg16 #(.W(REG_W), .MASK(MSK)) u_reg (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en & hit[r]),
        .wdata (wdata),
        .q     (regs[r*REG_W +: REG_W])
      );

      for (genvar b = 0; b < REG_W; b++) begin : g_bit
        localparam int DP = data_pin(r, b, NUM_PINS, HAS_OE_REG);
        if (DP >= 0) begin : g_data
          assign view[r*REG_W + b] = rb[DP];
        end else begin : g_plain
          assign view[r*REG_W + b] = regs[r*REG_W + b];
        end
      end
    end
  endgenerate

  // per-pin routing from register bits
  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      localparam int OL = out_loc(p, NUM_PINS, HAS_OE_REG);
      localparam int EL = oe_loc(p, NUM_PINS, HAS_OE_REG);

      if (OL >= 0) begin : g_out
        assign pin_out[p] = regs[OL];
      end else begin : g_out0
        assign pin_out[p] = 1'b0;
      end

      if (EL >= 0) begin : g_oe
        assign pin_oe[p] = regs[EL];
      end else if (EL == LOC_TIED) begin : g_oe1
        assign pin_oe[p] = 1'b1;
      end else begin : g_oe0
        assign pin_oe[p] = 1'b0;
      end

      if (HAS_PULL && p < PULL_PINS) begin : g_pull
        assign pull_en[p] = regs[R_PEN*REG_W + p];
        assign pull_up[p] = regs[R_PUP*REG_W + p];
      end else begin : g_nopull
        assign pull_en[p] = 1'b0;
        assign pull_up[p] = 1'b0;
      end

      assign rb[p] = pin_oe[p] ? pin_out[p] : pad_s[p];
    end
  endgenerate

  always_comb begin
    sel = '0;
    for (int r = 0; r < NREG; r++)
      if (hit[r]) sel = view[r*REG_W +: REG_W];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel;
  end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 50,
  parameter bit HAS_PULL = 1'b1,
  parameter int ADDR_W   = 9
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [REG_W-1:0]    wdata,
  input logic [REG_W-1:0]    rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] pull_en,
  input logic [NUM_PINS-1:0] pull_up
);

  logic mapped;
  always_comb begin
    mapped = 1'b0;
    for (int r = 0; r < NREG; r++)
      if (addr == ADDR_W'(reg_offset(r))) mapped = 1'b1;
  end

  // R1: the cycle after reset, outputs and read data are cleared
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (pin_out == '0 && pull_en == '0 && pull_up == '0 && rdata == '0));

  // R2: a direction write lands on the enable of pin 0
  a_r2_dir_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'('h000)) |=> pin_oe[0] == $past(wdata[0]));

  // R3: pin outputs move only on writes
  a_r3_quiet_pins: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pull_en) && $stable(pull_up)));

  // R4: readback of an output pin returns its driven value
  a_r4_out_readback: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && addr == ADDR_W'('h004) && pin_oe[0]) |=> rdata[0] == $past(pin_out[0]));

  // R8: writing the pull enable register never moves the pull direction
  a_r8_keep_polarity: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'('h1E0)) |=> $stable(pull_up));

  // R9: unmapped offsets read zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> rdata == '0);

  // R10: read data holds without a read strobe
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

endmodule

bind gpio_port gpio_port_chk #(
  .NUM_PINS (NUM_PINS),
  .HAS_PULL (HAS_PULL),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .pin_out (pin_out),
  .pin_oe  (pin_oe),
  .pull_en (pull_en),
  .pull_up (pull_up)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        wr0 = 1'b0, rd0 = 1'b0, wr1 = 1'b0, rd1 = 1'b0;
  logic [8:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata0, rdata1;
  logic [49:0] pin_in0 = '0, out0, oe0, pe0, pu0;
  logic [47:0] pin_in1 = '0, out1, oe1, pe1, pu1;

  gpio_port u0 (
    .clk(clk), .rst(rst), .wr_en(wr0), .rd_en(rd0), .addr(addr), .wdata(wdata),
    .rdata(rdata0), .pin_in(pin_in0), .pin_out(out0), .pin_oe(oe0),
    .pull_en(pe0), .pull_up(pu0)
  );

  gpio_port #(.NUM_PINS(48), .HAS_PULL(1'b0), .HAS_OE_REG(1'b1)) u1 (
    .clk(clk), .rst(rst), .wr_en(wr1), .rd_en(rd1), .addr(addr), .wdata(wdata),
    .rdata(rdata1), .pin_in(pin_in1), .pin_out(out1), .pin_oe(oe1),
    .pull_en(pe1), .pull_up(pu1)
  );

  typedef struct {
    bit          inst;
    logic [8:0]  a;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int n_chk = 0;
  int n_bad = 0;
  logic pend = 1'b0;

  // monitor: a read strobe seen at an edge is compared at the next falling edge
  always @(posedge clk) pend <= rd0 | rd1;

  always @(negedge clk) begin
    item_t it;
    logic [15:0] got;
    if (pend) begin
      n_chk++;
      if (sbq.size() == 0) begin
        n_bad++;
        $display("FAIL R10 unexpected read result actual=%h expected=none", rdata0);
      end else begin
        it  = sbq.pop_front();
        got = it.inst ? rdata1 : rdata0;
        if (got !== it.exp) begin
          n_bad++;
          $display("FAIL %s read u%0d @%h actual=%h expected=%h", it.tag, it.inst, it.a, got, it.exp);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit inst, input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (inst) wr1 = 1'b1; else wr0 = 1'b1;
    @(negedge clk);
    wr0 = 1'b0; wr1 = 1'b0;
  endtask

  task automatic rd(input bit inst, input logic [8:0] a, input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.inst = inst; it.a = a; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    addr = a;
    if (inst) rd1 = 1'b1; else rd0 = 1'b1;
    @(negedge clk);
    rd0 = 1'b0; rd1 = 1'b0;
  endtask

  task automatic wr_rd(input logic [8:0] a, input logic [15:0] d, input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.inst = 1'b0; it.a = a; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    addr = a; wdata = d; wr0 = 1'b1; rd0 = 1'b1;
    @(negedge clk);
    wr0 = 1'b0; rd0 = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [49:0] snap_oe, snap_out;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 u0 pin_oe", 64'(oe0), 64'({2'b00, 16'hFFFF, 32'h0}));
    chk("R1 u0 pin_out", 64'(out0), 64'h0);
    chk("R1 u0 pull", 64'({pe0, pu0}), 64'h0);
    chk("R1 u1 pin_oe", 64'(oe1), 64'h0);
    rd(0, 9'h000, 16'h0000, "R1");
    rd(0, 9'h004, 16'h0000, "R1");
    rd(0, 9'h01C, 16'h0000, "R1");
    rd(0, 9'h1E2, 16'h0000, "R1");

    // R2 direction
    wr(0, 9'h000, 16'h00F0);
    wr(0, 9'h002, 16'h8001);
    chk("R2 u0 pin_oe low", 64'(oe0[31:0]), 64'h8001_00F0);
    rd(0, 9'h002, 16'h8001, "R2");

    // R3 output data
    wr(0, 9'h004, 16'h1234);
    wr(0, 9'h006, 16'hFFFF);
    chk("R3 u0 pin_out low", 64'(out0[31:0]), 64'hFFFF_1234);

    // R4 mixed readback through the synchronizer
    pin_in0[15:0]  = 16'hAAAA;
    pin_in0[31:16] = 16'h0F00;
    settle();
    rd(0, 9'h004, (16'h1234 & 16'h00F0) | (16'hAAAA & ~16'h00F0), "R4");
    rd(0, 9'h006, (16'hFFFF & 16'h8001) | (16'h0F00 & ~16'h8001), "R4");

    // R5 packed-enable upper pins
    wr(0, 9'h01C, 16'h5A5A);
    chk("R5 u0 out 32-47", 64'(out0[47:32]), 64'h5A5A);
    chk("R5 u0 oe 32-47", 64'(oe0[47:32]), 64'hFFFF);
    pin_in0[47:32] = 16'hFFFF;
    settle();
    rd(0, 9'h01C, 16'h5A5A, "R5");
    wr(0, 9'h01E, 16'hFFFF);
    chk("R5 u0 oe 48-49", 64'(oe0[49:48]), 64'h3);
    chk("R5 u0 out 48-49", 64'(out0[49:48]), 64'h3);
    rd(0, 9'h01E, 16'h0303, "R5 R9");
    wr(0, 9'h01E, 16'h0103);
    chk("R5 u0 oe 48-49 after clear", 64'(oe0[49:48]), 64'h1);
    rd(0, 9'h01E, 16'h0101, "R5");
    pin_in0[49] = 1'b1;
    settle();
    rd(0, 9'h01E, 16'h0103, "R5 R4");

    // R7 pull control
    wr(0, 9'h1E2, 16'hFFFF);
    chk("R7 u0 pull_up", 64'(pu0), 64'h7FFF);
    rd(0, 9'h1E2, 16'h7FFF, "R7");
    wr(0, 9'h1E0, 16'h0005);
    chk("R7 u0 pull_en", 64'(pe0), 64'h0005);

    // R8 disabling pull keeps direction
    wr(0, 9'h1E0, 16'h0000);
    chk("R8 u0 pull_en off", 64'(pe0), 64'h0);
    chk("R8 u0 pull_up kept", 64'(pu0), 64'h7FFF);
    rd(0, 9'h1E2, 16'h7FFF, "R8");

    // R9 unmapped and odd offsets
    snap_oe  = oe0;
    snap_out = out0;
    wr(0, 9'h008, 16'hFFFF);
    wr(0, 9'h001, 16'hFFFF);
    wr(0, 9'h1E4, 16'hFFFF);
    chk("R9 u0 pin_oe untouched", 64'(oe0), 64'(snap_oe));
    chk("R9 u0 pin_out untouched", 64'(out0), 64'(snap_out));
    chk("R9 u0 pull untouched", 64'(pe0), 64'h0);
    rd(0, 9'h008, 16'h0000, "R9");
    rd(0, 9'h001, 16'h0000, "R9");

    // R10 read during write returns the old value, then holds
    wr_rd(9'h004, 16'h0F0F, (16'h1234 & 16'h00F0) | (16'hAAAA & ~16'h00F0), "R10");
    rd(0, 9'h004, (16'h0F0F & 16'h00F0) | (16'hAAAA & ~16'h00F0), "R10");
    repeat (3) @(negedge clk);
    chk("R10 rdata holds", 64'(rdata0), 64'(16'hAA0A));

    // R6 dedicated enable register build
    wr(1, 9'h01C, 16'h00FF);
    wr(1, 9'h01E, 16'h0F0F);
    chk("R6 u1 oe 32-47", 64'(oe1[47:32]), 64'h00FF);
    chk("R6 u1 out 32-47", 64'(out1[47:32]), 64'h0F0F);
    chk("R6 u1 oe low untouched", 64'(oe1[31:0]), 64'h0);
    pin_in1[47:32] = 16'hF000;
    settle();
    rd(1, 9'h01E, (16'h0F0F & 16'h00FF) | (16'hF000 & ~16'h00FF), "R6");
    rd(1, 9'h01C, 16'h00FF, "R6");

    // R7 R9 no pull control in the second build
    wr(1, 9'h1E0, 16'hFFFF);
    wr(1, 9'h1E2, 16'hFFFF);
    chk("R7 u1 pull outputs", 64'({pe1, pu1}), 64'h0);
    rd(1, 9'h1E0, 16'h0000, "R9");

    repeat (3) @(negedge clk);
    if (sbq.size() != 0) begin
      n_chk++;
      n_bad++;
      $display("FAIL R10 pending reads actual=%0d expected=0", sbq.size());
    end
    summary();
    $finish;
  end

endmodule